// File: doc/BRIEF.md
# Bit Clock and Frame Sync Generator

This block makes the serial bit clock and the periodic frame sync that a master-mode audio serial port hands to its transmitter and receiver. All of its logic runs on one system clock. The generator counts source ticks to make the bit clock. A source tick is either every system clock cycle or each rising edge of the receive clock pin, after that pin has been synchronised. A frame counter then counts bit clocks. It drives a frame sync whose active width and whose frame period are both written as "value minus one". For example, a width of 15 and a period of 31 give a left/right clock with 50% duty for two 16-bit words.

Start-up has two stages. The clock generator enable comes first, and the frame sync enable follows once the bit clock runs. Dropping both enables stops everything. In the default mode frames repeat without pause. In the other mode one frame runs only after a load pulse, which stands for a data write.

Four lane selects choose the source of each serial port signal: transmit clock, receive clock, transmit frame sync and receive frame sync. Each one is either the internally generated signal or the matching pin, synchronised into the system clock domain.

Top module: `frame_clock_gen`

## Requirements
- R1: While reset is held, and right after it is released, all six outputs are low.
- R2: With `gen_en` high, `gen_bclk` is a square wave that starts low. Its high phase lasts `clk_div`+1 source ticks, and its low phase lasts the same.
- R3: With `src_ext` low, every system clock cycle is a source tick. With `src_ext` high, only a rising edge of `rx_clk_pin` is a tick, so a static pin stops the bit clock.
- R4: With `fs_periodic` high, one frame lasts `fs_period`+1 bit clocks, and `gen_fs` changes only when `gen_bclk` falls.
- R5: `gen_fs` goes active at count 0 of each frame and stays active for `fs_width`+1 bit clocks.
- R6: If `fs_width` >= `fs_period`, `gen_fs` stays active through every frame without a gap.
- R7: `fs_en` has no effect while `gen_en` is low, so both `gen_bclk` and `gen_fs` stay low. With `gen_en` high and `fs_en` low, `gen_bclk` runs and `gen_fs` stays low.
- R8: Clearing both enables drives `gen_bclk` and `gen_fs` low at the next clock edge, and both then stay low.
- R9: With `fs_periodic` low, no frame starts until `load_pulse` is seen. A single pulse gives exactly one frame, with `fs_width`+1 active bit clocks, and then `gen_fs` stays low.
- R10: Each of the four lane outputs equals the internal signal when its select is 1. The clock lanes take `gen_bclk` and the frame sync lanes take `gen_fs`. When the select is 0, the lane output equals its pin, delayed by two system clocks through a synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_en | input | 1 | Clock generator enable (first stage) |
| fs_en | input | 1 | Frame sync generation enable (second stage) |
| fs_periodic | input | 1 | 1: frames repeat without pause; 0: one frame per load pulse |
| src_ext | input | 1 | 1: generator ticks on receive clock pin rising edges |
| clk_div | input | DIV_W | Bit clock half period in source ticks, minus one |
| fs_width | input | FRAME_W | Active frame sync width in bit clocks, minus one |
| fs_period | input | FRAME_W | Frame length in bit clocks, minus one |
| load_pulse | input | 1 | Data-write request that starts one frame in triggered mode |
| tx_clk_sel_int | input | 1 | Transmit clock lane: 1 internal, 0 pin |
| rx_clk_sel_int | input | 1 | Receive clock lane: 1 internal, 0 pin |
| tx_fs_sel_int | input | 1 | Transmit frame sync lane: 1 internal, 0 pin |
| rx_fs_sel_int | input | 1 | Receive frame sync lane: 1 internal, 0 pin |
| tx_clk_pin | input | 1 | External transmit clock |
| rx_clk_pin | input | 1 | External receive clock, also the external generator source |
| tx_fs_pin | input | 1 | External transmit frame sync |
| rx_fs_pin | input | 1 | External receive frame sync |
| gen_bclk | output | 1 | Generated bit clock |
| gen_fs | output | 1 | Generated frame sync, active high |
| tx_clk_o | output | 1 | Selected transmit clock |
| rx_clk_o | output | 1 | Selected receive clock |
| tx_fs_o | output | 1 | Selected transmit frame sync |
| rx_fs_o | output | 1 | Selected receive frame sync |

## Verification
On every cycle, the assertions check three things. The bit clock moves only on a source tick or on disable. The frame sync moves only at a bit clock fall or on disable. Dropping either enable silences the outputs that enable controls. The directed scenarios are the only evidence for the quantities that span many cycles: the half-period lengths, the width and period counted in bit clocks, and the saturation case. They also cover the external-source rate, the single frame after one load pulse, and the lane multiplexing through the synchroniser delay.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int unsigned NUM_LANES = 4;

  typedef enum logic [1:0] {
    LANE_TX_CLK = 2'd0,
    LANE_RX_CLK = 2'd1,
    LANE_TX_FS  = 2'd2,
    LANE_RX_FS  = 2'd3
  } lane_e;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_RUN  = 1'b1
  } frame_state_e;

  function automatic logic lane_is_clock(input int unsigned lane);
    return (lane == int'(LANE_TX_CLK)) || (lane == int'(LANE_RX_CLK));
  endfunction
endpackage

// File: rtl/fcg_rst_sync.sv
module fcg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/fcg_pin_sync.sv
module fcg_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level_o = sh_q[STAGES-1];
endmodule

// File: rtl/fcg_clk_div.sv
module fcg_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             bit_end_o
);
  localparam logic [DIV_W-1:0] DIV_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;
  logic             wrap;

  always_comb begin
    wrap      = en_i && tick_i && (cnt_q >= div_i);
    cnt_d     = cnt_q;
    bclk_d    = bclk_q;
    if (!en_i) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_d  = '0;
        bclk_d = ~bclk_q;
      end else begin
        cnt_d  = cnt_q + DIV_ONE;
      end
    end
    bit_end_o = wrap && bclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk_o = bclk_q;

  // R2 R3
  bclk_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk_q) |-> ($past(tick_i) || !$past(en_i)));

  // R8
  div_idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!bclk_q && cnt_q == '0));
endmodule

// File: rtl/fcg_frame_ctr.sv
module fcg_frame_ctr
  import fcg_pkg::*;
#(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               periodic_i,
  input  logic               load_i,
  input  logic               bit_end_i,
  input  logic [FRAME_W-1:0] width_i,
  input  logic [FRAME_W-1:0] period_i,
  output logic               fs_o
);
  localparam logic [FRAME_W-1:0] FR_ONE = {{(FRAME_W-1){1'b0}}, 1'b1};

  frame_state_e      st_q, st_d;
  logic [FRAME_W-1:0] cnt_q, cnt_d;
  logic               pend_q, pend_d;
  logic               fs_q, fs_d;
  logic               want_frame;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    pend_d     = pend_q | load_i;
    fs_d       = fs_q;
    want_frame = periodic_i || pend_d;
    if (!en_i) begin
      st_d   = FR_IDLE;
      cnt_d  = '0;
      pend_d = 1'b0;
      fs_d   = 1'b0;
    end else if (bit_end_i) begin
      if (st_q == FR_IDLE) begin
        if (want_frame) begin
          st_d   = FR_RUN;
          cnt_d  = '0;
          pend_d = 1'b0;
        end
      end else if (cnt_q >= period_i) begin
        cnt_d = '0;
        if (want_frame) pend_d = 1'b0;
        else            st_d   = FR_IDLE;
      end else begin
        cnt_d = cnt_q + FR_ONE;
      end
      fs_d = (st_d == FR_RUN) && (cnt_d <= width_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      fs_q   <= fs_d;
    end
  end

  assign fs_o = fs_q;

  // R4
  fs_moves_on_bit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_q) |-> ($past(bit_end_i) || !$past(en_i)));

  // R5
  fs_active_at_count0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_RUN && cnt_q == '0) |-> fs_q);

  // R9
  idle_means_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_IDLE) |-> !fs_q);
endmodule

// File: rtl/frame_clock_gen.sv
module frame_clock_gen
  import fcg_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gen_en,
  input  logic               fs_en,
  input  logic               fs_periodic,
  input  logic               src_ext,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic [FRAME_W-1:0] fs_width,
  input  logic [FRAME_W-1:0] fs_period,
  input  logic               load_pulse,
  input  logic               tx_clk_sel_int,
  input  logic               rx_clk_sel_int,
  input  logic               tx_fs_sel_int,
  input  logic               rx_fs_sel_int,
  input  logic               tx_clk_pin,
  input  logic               rx_clk_pin,
  input  logic               tx_fs_pin,
  input  logic               rx_fs_pin,
  output logic               gen_bclk,
  output logic               gen_fs,
  output logic               tx_clk_o,
  output logic               rx_clk_o,
  output logic               tx_fs_o,
  output logic               rx_fs_o
);
  logic                 rst_int_n;
  logic [NUM_LANES-1:0] pin_vec, pin_sync, sel_vec, lane_out;
  logic                 rx_prev_q;
  logic                 src_tick;
  logic                 bit_end;
  logic                 fs_run_en;

  fcg_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  assign pin_vec[LANE_TX_CLK] = tx_clk_pin;
  assign pin_vec[LANE_RX_CLK] = rx_clk_pin;
  assign pin_vec[LANE_TX_FS]  = tx_fs_pin;
  assign pin_vec[LANE_RX_FS]  = rx_fs_pin;
  assign sel_vec[LANE_TX_CLK] = tx_clk_sel_int;
  assign sel_vec[LANE_RX_CLK] = rx_clk_sel_int;
  assign sel_vec[LANE_TX_FS]  = tx_fs_sel_int;
  assign sel_vec[LANE_RX_FS]  = rx_fs_sel_int;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    fcg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .pin_i   (pin_vec[g]),
      .level_o (pin_sync[g])
    );
    if (lane_is_clock(g)) begin : g_clk
      assign lane_out[g] = sel_vec[g] ? gen_bclk : pin_sync[g];
    end else begin : g_fs
      assign lane_out[g] = sel_vec[g] ? gen_fs : pin_sync[g];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rx_prev_q <= 1'b0;
    else            rx_prev_q <= pin_sync[LANE_RX_CLK];
  end

  always_comb begin
    if (src_ext) src_tick = pin_sync[LANE_RX_CLK] && !rx_prev_q;
    else         src_tick = 1'b1;
    fs_run_en = gen_en && fs_en;
  end

  fcg_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en_i      (gen_en),
    .tick_i    (src_tick),
    .div_i     (clk_div),
    .bclk_o    (gen_bclk),
    .bit_end_o (bit_end)
  );

  fcg_frame_ctr #(.FRAME_W(FRAME_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_i       (fs_run_en),
    .periodic_i (fs_periodic),
    .load_i     (load_pulse),
    .bit_end_i  (bit_end),
    .width_i    (fs_width),
    .period_i   (fs_period),
    .fs_o       (gen_fs)
  );

  assign tx_clk_o = lane_out[LANE_TX_CLK];
  assign rx_clk_o = lane_out[LANE_RX_CLK];
  assign tx_fs_o  = lane_out[LANE_TX_FS];
  assign rx_fs_o  = lane_out[LANE_RX_FS];

  // R7
  fs_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fs_en |=> !gen_fs);

  // R8
  stop_all_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!gen_en && !fs_en) |=> (!gen_bclk && !gen_fs));

  // R3
  ext_static_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (src_ext && $stable(pin_sync[LANE_RX_CLK]) && gen_en && $past(gen_en)) |=> $stable(gen_bclk));
endmodule

// File: tb/frame_clock_gen_tb_top.sv
module frame_clock_gen_tb_top;
  localparam int DIV_W = 8;
  localparam int FRAME_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, gen_en, fs_en, fs_periodic, src_ext, load_pulse;
  logic [DIV_W-1:0] clk_div;
  logic [FRAME_W-1:0] fs_width, fs_period;
  logic tx_clk_sel_int, rx_clk_sel_int, tx_fs_sel_int, rx_fs_sel_int;
  logic tx_clk_pin, rx_clk_pin, tx_fs_pin, rx_fs_pin;
  logic gen_bclk, gen_fs, tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o;
  logic ext_run;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  frame_clock_gen #(.DIV_W(DIV_W), .FRAME_W(FRAME_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fs_en(fs_en),
    .fs_periodic(fs_periodic), .src_ext(src_ext), .clk_div(clk_div),
    .fs_width(fs_width), .fs_period(fs_period), .load_pulse(load_pulse),
    .tx_clk_sel_int(tx_clk_sel_int), .rx_clk_sel_int(rx_clk_sel_int),
    .tx_fs_sel_int(tx_fs_sel_int), .rx_fs_sel_int(rx_fs_sel_int),
    .tx_clk_pin(tx_clk_pin), .rx_clk_pin(rx_clk_pin),
    .tx_fs_pin(tx_fs_pin), .rx_fs_pin(rx_fs_pin),
    .gen_bclk(gen_bclk), .gen_fs(gen_fs), .tx_clk_o(tx_clk_o),
    .rx_clk_o(rx_clk_o), .tx_fs_o(tx_fs_o), .rx_fs_o(rx_fs_o)
  );

  // external receive clock: 3 cycles high, 3 low
  always begin
    if (ext_run === 1'b1) begin
      rx_clk_pin = 1'b1;
      repeat (3) @(negedge clk);
      rx_clk_pin = 1'b0;
      repeat (3) @(negedge clk);
    end else begin
      @(negedge clk);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_fall();
    logic p;
    p = gen_bclk;
    @(negedge clk);
    while (!(p && !gen_bclk)) begin
      p = gen_bclk;
      @(negedge clk);
    end
  endtask

  task automatic measure_frame(output int hi, output int lo);
    next_fall();
    while (gen_fs) next_fall();
    while (!gen_fs) next_fall();
    hi = 0;
    while (gen_fs) begin hi++; next_fall(); end
    lo = 0;
    while (!gen_fs) begin lo++; next_fall(); end
  endtask

  task automatic idle_cfg();
    gen_en = 0; fs_en = 0; fs_periodic = 1; src_ext = 0; load_pulse = 0;
    clk_div = '0; fs_width = '0; fs_period = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk({gen_bclk, gen_fs, tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o} == 6'b0, "R1 during reset",
        int'({gen_bclk, gen_fs, tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({gen_bclk, gen_fs, tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o} == 6'b0, "R1 after release",
        int'({gen_bclk, gen_fs, tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o}), 0);
  endtask

  task automatic t_half_period(input int div);
    int hi, lo;
    idle_cfg();
    clk_div = DIV_W'(div);
    gen_en = 1;
    while (gen_bclk) @(negedge clk);
    while (!gen_bclk) @(negedge clk);
    hi = 0;
    while (gen_bclk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!gen_bclk) begin lo++; @(negedge clk); end
    chk(hi == div + 1, "R2 high phase", hi, div + 1);
    chk(lo == div + 1, "R2 low phase", lo, div + 1);
  endtask

  task automatic t_frame(input int w, input int p, input int div);
    int hi, lo;
    idle_cfg();
    clk_div = DIV_W'(div); fs_width = FRAME_W'(w); fs_period = FRAME_W'(p);
    gen_en = 1;
    repeat (5) @(negedge clk);
    fs_en = 1;
    measure_frame(hi, lo);
    chk(hi == w + 1, "R5 active width", hi, w + 1);
    chk(hi + lo == p + 1, "R4 frame period", hi + lo, p + 1);
  endtask

  task automatic t_saturate();
    int lows;
    idle_cfg();
    fs_width = 8'd9; fs_period = 8'd5;
    gen_en = 1; fs_en = 1;
    next_fall();
    lows = 0;
    for (int i = 0; i < 18; i++) begin
      next_fall();
      if (!gen_fs) lows++;
    end
    chk(lows == 0, "R6 width beyond period", lows, 0);
  endtask

  task automatic t_two_stage();
    int bc, fc;
    idle_cfg();
    fs_width = 8'd1; fs_period = 8'd3;
    fs_en = 1;
    bc = 0; fc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gen_bclk) bc++;
      if (gen_fs) fc++;
    end
    chk(bc == 0 && fc == 0, "R7 fs_en alone is ignored", bc + fc, 0);
    fs_en = 0; gen_en = 1;
    bc = 0; fc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gen_bclk) bc++;
      if (gen_fs) fc++;
    end
    chk(bc == 20, "R7 bit clock runs without fs_en", bc, 20);
    chk(fc == 0, "R7 fs stays low without fs_en", fc, 0);
  endtask

  task automatic t_stop();
    int act;
    idle_cfg();
    fs_width = 8'd7; fs_period = 8'd7;
    gen_en = 1; fs_en = 1;
    next_fall(); next_fall();
    chk(gen_fs == 1'b1, "R8 running before stop", int'(gen_fs), 1);
    gen_en = 0; fs_en = 0;
    @(negedge clk);
    chk(!gen_bclk && !gen_fs, "R8 low after one edge", int'({gen_bclk, gen_fs}), 0);
    act = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (gen_bclk || gen_fs) act++;
    end
    chk(act == 0, "R8 stays low", act, 0);
  endtask

  task automatic t_ext_source();
    int rises;
    logic p;
    idle_cfg();
    ext_run = 0; rx_clk_pin = 0;
    src_ext = 1; gen_en = 1;
    rises = 0; p = gen_bclk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!p && gen_bclk) rises++;
      p = gen_bclk;
    end
    chk(rises == 0, "R3 static pin gives no ticks", rises, 0);
    ext_run = 1;
    repeat (12) @(negedge clk);
    rises = 0; p = gen_bclk;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (!p && gen_bclk) rises++;
      p = gen_bclk;
    end
    chk(rises >= 9 && rises <= 11, "R3 external tick rate", rises, 10);
    ext_run = 0;
    repeat (8) @(negedge clk);
    rx_clk_pin = 0;
  endtask

  task automatic t_trigger();
    int hi;
    idle_cfg();
    fs_periodic = 0; fs_width = 8'd2; fs_period = 8'd5;
    gen_en = 1; fs_en = 1;
    hi = 0;
    for (int i = 0; i < 20; i++) begin next_fall(); if (gen_fs) hi++; end
    chk(hi == 0, "R9 no frame without load", hi, 0);
    load_pulse = 1;
    @(negedge clk);
    load_pulse = 0;
    hi = 0;
    for (int i = 0; i < 24; i++) begin next_fall(); if (gen_fs) hi++; end
    chk(hi == 3, "R9 one frame per load", hi, 3);
  endtask

  task automatic t_lanes();
    int mism;
    idle_cfg();
    fs_width = 8'd1; fs_period = 8'd3;
    gen_en = 1; fs_en = 1;
    tx_clk_sel_int = 1; rx_clk_sel_int = 1; tx_fs_sel_int = 1; rx_fs_sel_int = 1;
    mism = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_clk_o !== gen_bclk || rx_clk_o !== gen_bclk ||
          tx_fs_o !== gen_fs || rx_fs_o !== gen_fs) mism++;
    end
    chk(mism == 0, "R10 internal lanes", mism, 0);
    tx_clk_sel_int = 0; rx_clk_sel_int = 0; tx_fs_sel_int = 0; rx_fs_sel_int = 0;
    {tx_clk_pin, rx_clk_pin, tx_fs_pin, rx_fs_pin} = 4'b1010;
    @(negedge clk);
    chk({tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o} == 4'b0000, "R10 pin not yet through",
        int'({tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o}), 0);
    repeat (2) @(negedge clk);
    chk({tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o} == 4'b1010, "R10 pin lanes 1010",
        int'({tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o}), 10);
    {tx_clk_pin, rx_clk_pin, tx_fs_pin, rx_fs_pin} = 4'b0101;
    repeat (3) @(negedge clk);
    chk({tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o} == 4'b0101, "R10 pin lanes 0101",
        int'({tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o}), 5);
    {tx_clk_pin, rx_clk_pin, tx_fs_pin, rx_fs_pin} = 4'b0000;
    tx_clk_sel_int = 1; rx_clk_sel_int = 1; tx_fs_sel_int = 1; rx_fs_sel_int = 1;
  endtask

  initial begin
    ext_run = 0;
    rst_n = 0; gen_en = 0; fs_en = 0; fs_periodic = 1; src_ext = 0; load_pulse = 0;
    clk_div = '0; fs_width = '0; fs_period = '0;
    tx_clk_sel_int = 1; rx_clk_sel_int = 1; tx_fs_sel_int = 1; rx_fs_sel_int = 1;
    tx_clk_pin = 0; rx_clk_pin = 0; tx_fs_pin = 0; rx_fs_pin = 0;
    t_reset();
    t_half_period(2);
    t_half_period(0);
    t_frame(3, 7, 0);
    t_frame(15, 31, 1);
    t_saturate();
    t_two_stage();
    t_stop();
    t_ext_source();
    t_trigger();
    t_lanes();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule